// File: doc/BRIEF.md
# Resampling Step Estimator with Pointer Servo

This block supplies the step value for an asynchronous sample-rate converter. The step is the number of input samples the output read position advances per output sample. A free-running counter on the system clock is stamped into one short history on every input-sample event and into a second history on every output-sample event. The time spanned by each history gives the mean input and output periods. An iterative fixed-point divider turns their ratio into a nominal step.

A proportional-integral servo refines that nominal value on every output sample. It tracks a fractional output pointer, which advances by each step it hands out, and an integer input pointer, which counts input events. Its error is the distance of the output pointer from a target position held a programmable number of samples behind the input pointer. A positive error means the output is too close to the input, and it lowers the step. Until both histories are full and a first ratio has been divided out, the block passes a programmable default step. Both event inputs are single-cycle pulses that have already been brought into the system clock domain.

Top module: `resamp_step_est`

## Requirements
- R1: While reset is held and directly after it, step_out equals default_step, ratio_valid is 0 and div_busy is 0.
- R2: ratio_valid stays 0 until each history holds HIST_DEPTH captures (default 16). Meanwhile step_out equals default_step and follows changes to it on the next cycle.
- R3: The step has 28 bits: 4 integer bits and 24 fraction bits. The nominal step is floor(span_out·2^24/span_in). Each span is newest minus oldest stamp in its history, computed modulo 2^32. With input events every Tin cycles and output events every Tout cycles, it is floor(Tout·2^24/Tin).
- R4: The nominal step is clamped to [STEP_MIN, STEP_MAX], which default to 2^20 and 2^27.
- R5: A division starts on an output event when both histories are full and the divider is idle. div_busy is then high for exactly 56 consecutive cycles, starting on the next cycle.
- R6: Once ratio_valid is 1, step_out changes only in the cycle after an output event. Input events alone leave it unchanged.
- R7: The first output event after a nominal step exists raises ratio_valid and sets step_out to the nominal step. The output pointer is placed at the reference position plus that step, so the servo starts from zero error.
- R8: On each later output event, err = out_ptr − (in_count − lag_target)·2^24. Here out_ptr has advanced by every step published since R7. The new step is nominal − T(err, kp_shift) − T(I, ki_shift). T shifts the magnitude right and keeps the sign, so it truncates toward zero. A shift of 63 removes the term.
- R9: On each output event the integrator I is first updated to I + err and clamped to ±INTEG_LIM (default 2^22). That updated value is then used.
- R10: The published step is saturated to [STEP_MIN, STEP_MAX].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_evt | input | 1 | One-cycle pulse per input sample |
| out_evt | input | 1 | One-cycle pulse per output sample |
| default_step | input | 28 | Step passed through before the servo is live |
| kp_shift | input | 6 | Right shift of the proportional term |
| ki_shift | input | 6 | Right shift of the integral term |
| lag_target | input | 16 | Target distance, in samples, of the output pointer behind the input pointer |
| step_out | output | 28 | Step for the resampler, 4.24 unsigned fixed point |
| ratio_valid | output | 1 | Servo is live and step_out is the computed step |
| div_busy | output | 1 | Rate divider is running |

## Verification
A stale or corrupted history entry skews a span. It shows as a wrong nominal step on step_out within one division plus one output event, roughly 60 cycles. A divider that loses or repeats a quotient bit gives a step off by a power of two in the fraction. The same fault also shows at once as a wrong div_busy length. A servo whose pointer or integrator drifts gives a step that departs from the exact values expected on the first two servo updates. A faulty integrator clamp shows as a step missing the nominal ±INTEG_LIM value after a long one-sided run of events. A saturation fault shows as a step beyond the legal range once the error grows large.

// File: rtl/rse_pkg.sv
package rse_pkg;
  localparam int TS_W   = 32;
  localparam int FRAC_W = 24;
  localparam int INT_W  = 4;
  localparam int STEP_W = INT_W + FRAC_W;
  localparam int PI_W   = 16;
  localparam int FIX_W  = PI_W + FRAC_W;
  localparam int ACC_W  = FIX_W + 2;
  localparam int SH_W   = 6;

  typedef logic [TS_W-1:0]          ts_t;
  typedef logic [STEP_W-1:0]        step_t;
  typedef logic signed [FIX_W-1:0]  fix_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // elapsed stamps, modulo 2^TS_W
  function automatic ts_t ts_span(ts_t newest, ts_t oldest);
    return newest - oldest;
  endfunction

  // right shift of the magnitude, sign restored (truncation toward zero)
  function automatic fix_t shr_tz(fix_t x, logic [SH_W-1:0] sh);
    fix_t mag;
    if (x < 0) begin
      mag = -x;
      return -(mag >>> sh);
    end
    return x >>> sh;
  endfunction

  function automatic step_t sat_step(acc_t v, int lo, int hi);
    if (v < acc_t'(lo)) return step_t'(lo);
    if (v > acc_t'(hi)) return step_t'(hi);
    return step_t'(v);
  endfunction

  function automatic fix_t clamp_fix(acc_t v, int lim);
    if (v > acc_t'(lim))  return fix_t'(lim);
    if (v < -acc_t'(lim)) return -fix_t'(lim);
    return fix_t'(v);
  endfunction
endpackage

// File: rtl/rse_hist.sv
module rse_hist
  import rse_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  ts_t  stamp,
  output logic full,
  output ts_t  span
);
  localparam int CW = $clog2(DEPTH + 1);

  ts_t           mem [DEPTH];
  logic [CW-1:0] fill;

  always_ff @(posedge clk) begin
    if (!rst_n) mem[0] <= '0;
    else if (cap) mem[0] <= stamp;
  end

  for (genvar gi = 1; gi < DEPTH; gi++) begin : g_shift
    always_ff @(posedge clk) begin
      if (!rst_n) mem[gi] <= '0;
      else if (cap) mem[gi] <= mem[gi-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fill <= '0;
    else if (cap && fill != CW'(DEPTH)) fill <= fill + 1'b1;
  end

  assign full = (fill == CW'(DEPTH));
  assign span = ts_span(mem[0], mem[DEPTH-1]);

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full); // R2
endmodule

// File: rtl/rse_div.sv
module rse_div
  import rse_pkg::*;
#(
  parameter int STEP_MIN = 1 << 20,
  parameter int STEP_MAX = 8 << 24
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  ts_t   num,
  input  ts_t   den,
  output logic  busy,
  output step_t nom,
  output logic  nom_valid
);
  localparam int DW = TS_W + FRAC_W;
  localparam int CW = $clog2(DW + 1);

  ts_t           den_q;
  logic [TS_W:0] rem, rem_sh, rem_nx;
  logic [DW-1:0] dvd, quo, quo_nx;
  logic [CW-1:0] cnt;
  logic          ge;

  always_comb begin
    rem_sh = {rem[TS_W-1:0], dvd[DW-1]};
    ge     = (rem_sh >= {1'b0, den_q});
    rem_nx = ge ? rem_sh - {1'b0, den_q} : rem_sh;
    quo_nx = {quo[DW-2:0], ge};
  end

  function automatic step_t sat_quo(logic [DW-1:0] q);
    if (q > DW'(STEP_MAX)) return step_t'(STEP_MAX);
    if (q < DW'(STEP_MIN)) return step_t'(STEP_MIN);
    return step_t'(q);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; nom <= '0; nom_valid <= 1'b0;
      den_q <= '0; rem <= '0; dvd <= '0; quo <= '0; cnt <= '0;
    end else if (!busy) begin
      if (start) begin
        den_q <= den;
        dvd   <= {num, {FRAC_W{1'b0}}};
        rem   <= '0;
        quo   <= '0;
        cnt   <= CW'(DW);
        busy  <= 1'b1;
      end
    end else begin
      rem <= rem_nx;
      quo <= quo_nx;
      dvd <= dvd << 1;
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy      <= 1'b0;
        nom       <= sat_quo(quo_nx);
        nom_valid <= 1'b1;
      end
    end
  end

  // independent run-length counter for the busy window
  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run_len <= '0;
    else run_len <= run_len + 1'b1;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == (CW+1)'(DW))); // R5
  AST_NOM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    nom_valid |-> (nom >= step_t'(STEP_MIN) && nom <= step_t'(STEP_MAX))); // R4
endmodule

// File: rtl/rse_servo.sv
module rse_servo
  import rse_pkg::*;
#(
  parameter int STEP_MIN  = 1 << 20,
  parameter int STEP_MAX  = 8 << 24,
  parameter int INTEG_LIM = 1 << 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_evt,
  input  logic            out_evt,
  input  step_t           nom,
  input  logic            nom_valid,
  input  logic [SH_W-1:0] kp_sh,
  input  logic [SH_W-1:0] ki_sh,
  input  logic [PI_W-1:0] lag,
  output step_t           step_q,
  output logic            live
);
  logic [PI_W-1:0] in_cnt;
  fix_t out_ptr, integ, ref_pos, err, integ_nx, p_term, i_term;
  acc_t sum;
  step_t step_nx;

  always_comb begin
    ref_pos  = fix_t'({in_cnt - lag, {FRAC_W{1'b0}}});
    err      = out_ptr - ref_pos;
    integ_nx = clamp_fix(acc_t'(integ) + acc_t'(err), INTEG_LIM);
    p_term   = shr_tz(err, kp_sh);
    i_term   = shr_tz(integ_nx, ki_sh);
    sum      = acc_t'({1'b0, nom}) - acc_t'(p_term) - acc_t'(i_term);
    step_nx  = sat_step(sum, STEP_MIN, STEP_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_cnt <= '0;
    else if (in_evt) in_cnt <= in_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= 1'b0; step_q <= '0; out_ptr <= '0; integ <= '0;
    end else if (out_evt && nom_valid) begin
      if (!live) begin
        live    <= 1'b1;
        step_q  <= nom;
        integ   <= '0;
        out_ptr <= ref_pos + fix_t'({{(FIX_W-STEP_W){1'b0}}, nom});
      end else begin
        step_q  <= step_nx;
        integ   <= integ_nx;
        out_ptr <= out_ptr + fix_t'({{(FIX_W-STEP_W){1'b0}}, step_nx});
      end
    end
  end

  AST_INTEG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (integ <= fix_t'(INTEG_LIM)) && (integ >= -fix_t'(INTEG_LIM))); // R9
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (step_q >= step_t'(STEP_MIN) && step_q <= step_t'(STEP_MAX))); // R10
endmodule

// File: rtl/resamp_step_est.sv
module resamp_step_est
  import rse_pkg::*;
#(
  parameter int HIST_DEPTH = 16,
  parameter int STEP_MIN   = 1 << 20,
  parameter int STEP_MAX   = 8 << 24,
  parameter int INTEG_LIM  = 1 << 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_evt,
  input  logic              out_evt,
  input  logic [STEP_W-1:0] default_step,
  input  logic [SH_W-1:0]   kp_shift,
  input  logic [SH_W-1:0]   ki_shift,
  input  logic [PI_W-1:0]   lag_target,
  output logic [STEP_W-1:0] step_out,
  output logic              ratio_valid,
  output logic              div_busy
);
  ts_t   ts_cnt, span_in, span_out;
  logic  in_full, out_full, div_start, nom_valid, live;
  step_t nom, step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ts_cnt <= '0;
    else ts_cnt <= ts_cnt + 1'b1;
  end

  rse_hist #(.DEPTH(HIST_DEPTH)) u_hin (
    .clk(clk), .rst_n(rst_n), .cap(in_evt), .stamp(ts_cnt),
    .full(in_full), .span(span_in));

  rse_hist #(.DEPTH(HIST_DEPTH)) u_hout (
    .clk(clk), .rst_n(rst_n), .cap(out_evt), .stamp(ts_cnt),
    .full(out_full), .span(span_out));

  assign div_start = out_evt && in_full && out_full && !div_busy;

  rse_div #(.STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(span_out),
    .den(span_in), .busy(div_busy), .nom(nom), .nom_valid(nom_valid));

  rse_servo #(.STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .INTEG_LIM(INTEG_LIM)) u_srv (
    .clk(clk), .rst_n(rst_n), .in_evt(in_evt), .out_evt(out_evt),
    .nom(nom), .nom_valid(nom_valid), .kp_sh(kp_shift), .ki_sh(ki_shift),
    .lag(lag_target), .step_q(step_q), .live(live));

  assign step_out    = live ? step_q : default_step;
  assign ratio_valid = live;

  AST_LIVE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid |-> (in_full && out_full)); // R2
  AST_HOLD_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid && !out_evt) |=> $stable(step_out)); // R6
endmodule

// File: tb/sim_resamp_step_est.sv
module sim_resamp_step_est;
  localparam int CLK_PER = 10;
  localparam longint SMIN = 1 << 20;
  localparam longint SMAX = 8 << 24;
  localparam longint ILIM = 1 << 22;
  localparam longint DEF0 = 28'h0123456;
  localparam longint DEF1 = 28'h0ABCDEF;
  localparam int NV = 7;
  // stimulus: input period, output period; expected class 0 exact, 1 floor, 2 ceiling
  localparam int VT_IN   [NV] = '{10, 12, 9, 7, 13, 20, 1};
  localparam int VT_OUT  [NV] = '{12, 11, 9, 13, 5, 1, 12};
  localparam int VT_KIND [NV] = '{0, 0, 0, 0, 0, 1, 2};

  logic clk = 1'b0, rst_n = 1'b0, in_evt = 1'b0, out_evt = 1'b0;
  logic [27:0] default_step = 28'(DEF0);
  logic [5:0] kp_shift = 6'd2, ki_shift = 6'd63;
  logic [15:0] lag_target = 16'd4;
  logic [27:0] step_out;
  logic ratio_valid, div_busy;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  resamp_step_est u0 (
    .clk(clk), .rst_n(rst_n), .in_evt(in_evt), .out_evt(out_evt),
    .default_step(default_step), .kp_shift(kp_shift), .ki_shift(ki_shift),
    .lag_target(lag_target), .step_out(step_out), .ratio_valid(ratio_valid),
    .div_busy(div_busy));

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run(int tin, int tout, int ncyc, bit en_in, bit en_out);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      in_evt  = en_in  && (i % tin == 0);
      out_evt = en_out && (i % tout == 0);
    end
    @(negedge clk);
    in_evt = 1'b0; out_evt = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 step in reset", step_out, default_step);
    chk("R1 valid in reset", ratio_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 step after reset", step_out, default_step);
    chk("R1 valid after reset", ratio_valid, 0);
    chk("R1 busy after reset", div_busy, 0);
  endtask

  function automatic longint nom_of(int tin, int tout);
    longint q = (longint'(tout) << 24) / tin;
    if (q < SMIN) q = SMIN;
    if (q > SMAX) q = SMAX;
    return q;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint nom, acc, ex, s0;
    bit seen, prev;
    int k, nouts;
    do_reset();

    // R2: input history only
    for (int i = 0; i < 160; i++) begin
      @(negedge clk); in_evt = (i % 10 == 0);
    end
    @(negedge clk); in_evt = 1'b0;
    chk("R2 valid with out history empty", ratio_valid, 0);
    chk("R2 default passed", step_out, DEF0);
    default_step = 28'(DEF1);
    @(negedge clk);
    chk("R2 default followed", step_out, DEF1);

    // R7/R8: output events only, exact servo start
    nom = nom_of(10, 12);
    seen = 0; prev = 0; k = 0; nouts = 0; acc = 0;
    for (int j = 0; j < 3000 && k < 2; j++) begin
      @(negedge clk);
      if (prev) begin
        nouts++;
        if (!seen && ratio_valid) begin
          chk("R7 first live step", step_out, nom);
          seen = 1; acc = nom;
        end else if (seen) begin
          ex = nom - (acc >>> 2);
          chk("R8 servo step", step_out, ex);
          acc += ex; k++;
        end else if (nouts == 16) begin
          chk("R2 valid at 16 outputs", ratio_valid, 0);
        end
      end
      out_evt = (j % 12 == 0);
      prev = out_evt;
    end
    @(negedge clk); out_evt = 1'b0;
    chk("R7 servo went live", seen, 1);

    // R3/R4: rate table, servo terms off
    kp_shift = 6'd63; ki_shift = 6'd63;
    for (int v = 0; v < NV; v++) begin
      int mx = (VT_IN[v] > VT_OUT[v]) ? VT_IN[v] : VT_OUT[v];
      run(VT_IN[v], VT_OUT[v], 32 * mx + 100, 1, 1);
      ex = (VT_KIND[v] == 1) ? SMIN : (VT_KIND[v] == 2) ? SMAX : nom_of(VT_IN[v], VT_OUT[v]);
      chk((VT_KIND[v] == 0) ? "R3 nominal ratio" : "R4 nominal clamp", step_out, ex);
    end

    // R5: busy window
    run(1, 1, 100, 0, 0);
    chk("R5 idle", div_busy, 0);
    @(negedge clk); out_evt = 1'b1;
    @(negedge clk); out_evt = 1'b0;
    k = 0;
    while (div_busy && k < 200) begin k++; @(negedge clk); end
    chk("R5 busy length", k, 56);

    // R9/R6/R10: clamps after a fresh start
    kp_shift = 6'd63; ki_shift = 6'd0;
    do_reset();
    run(10, 12, 400, 1, 1);
    run(10, 12, 720, 0, 1);
    chk("R9 positive clamp", step_out, nom_of(10, 12) - ILIM);
    s0 = step_out;
    run(10, 12, 1000, 1, 0);
    chk("R6 inputs only", step_out, s0);
    run(1, 1, 1, 0, 1);
    chk("R9 negative clamp", step_out, nom_of(10, 12) + ILIM);
    kp_shift = 6'd0; ki_shift = 6'd63;
    run(10, 12, 1000, 1, 0);
    run(1, 1, 1, 0, 1);
    chk("R10 step ceiling", step_out, SMAX);
    run(10, 12, 1200, 0, 1);
    chk("R10 step floor", step_out, SMIN);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule